// File: doc/BRIEF.md
# Multi-Mode Register Structure

A small storage array, by default eight 32-bit entries, reached through a single register name. A configure command selects one of four access disciplines:
- a tapped queue, whose reads never consume anything;
- a popping FIFO queue;
- a ring of fixed length for values that are used over and over;
- a LIFO stack.

All four disciplines share one circular array. They differ only in how the read pointer, the write pointer and the entry count move on each access.

The read port is combinational. `rd_data_o` always shows the value that a read strobe in the current cycle would return. The strobe itself only moves state at the next clock edge.

The configure command loads the mode and a setup field, and empties the structure. A separate clear input empties the structure and keeps the mode and setup.

The setup field is used only in tapped-queue mode, where it gives the tap position, and in ring mode, where it gives the ring length. Underflow and overflow flags report misuse of the FIFO and stack modes in the same cycle as the access.

Top module: `multimode_regstruct`

## Requirements
- R1: After reset the block is in FIFO mode (code 1) with setup 0 and holds no entries. A cycle with `cfg_load_i` high loads mode and setup and empties the block. A cycle with `clr_i` high empties it and keeps mode and setup. In either cycle, reads and writes change nothing and raise no flag.
- R2: Mode code 0 (tapped queue): `rd_data_o` is the value written P writes ago, where P is the setup value and setup 0 means DEPTH. It reads zero until at least P writes have happened since the block was last emptied.
- R3: In tapped-queue mode every write moves all stored values one place older and drops the oldest once DEPTH values are held. A read strobe never changes what is held.
- R4: Mode code 1 (FIFO): reads return values in write order and each read removes one value. A write never changes which value is returned next.
- R5: In FIFO and stack modes, a read strobe while empty returns zero, pulses `underflow_o` in that cycle and changes no state.
- R6: In FIFO and stack modes, a write while DEPTH entries are held pulses `overflow_o` in that cycle and is dropped. The entry count never exceeds DEPTH.
- R7: Mode code 2 (ring): the length L is the setup value, with setup 0 meaning DEPTH. Writes fill entries in order until L entries are held, and later writes are ignored without a flag. Each read returns the current entry and steps to the next filled entry, wrapping after the last one. With no entries, the ring reads zero.
- R8: Mode code 3 (stack): a write pushes a value on top, and a read returns the top value and pops it.
- R9: When a read and a write come in the same cycle, the read returns the value from before the write. Both pointer updates then apply, and all empty and full decisions use the state from before that cycle.
- R10: The setup value has no effect in FIFO and stack modes.
- R11: `rd_data_o`, `underflow_o` and `overflow_o` follow the current state and inputs combinationally. A write or read shows its effect on `rd_data_o` right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load mode and setup, empty the structure |
| cfg_mode_i | input | 2 | Mode code: 0 tapped queue, 1 FIFO, 2 ring, 3 stack |
| cfg_setup_i | input | $clog2(DEPTH) | Tap position or ring length; 0 means DEPTH |
| clr_i | input | 1 | Empty the structure, keep configuration |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | WIDTH | Value a read returns in this cycle |
| underflow_o | output | 1 | Read of an empty FIFO or stack |
| overflow_o | output | 1 | Dropped write to a full FIFO or stack |

## Verification
Every output is a function of the registered state and the present inputs. A value written at one edge is therefore due on `rd_data_o` in the same clock period, right after that edge. A flag is due in the very cycle its strobe is asserted. The bench drives inputs at the falling edge and compares against its queue-based model 1 ns later, before the next rising edge. It advances the model at the rising edge, so every comparison sees the state from before the edge together with the new inputs, which is exactly the window in which the outputs are due.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    RS_TAPQ = 2'd0,
    RS_POPQ = 2'd1,
    RS_RING = 2'd2,
    RS_LIFO = 2'd3
  } rs_mode_e;
endpackage

// File: rtl/rs_cfg_reg.sv
module rs_cfg_reg
  import rs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic [PTR_W-1:0] setup_i,
  output rs_mode_e         mode_o,
  output logic [CNT_W-1:0] span_o
);
  rs_mode_e         mode_q;
  logic [PTR_W-1:0] setup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= RS_POPQ;
      setup_q <= '0;
    end else if (load_i) begin
      mode_q  <= rs_mode_e'(mode_i);
      setup_q <= setup_i;
    end
  end

  // setup 0 encodes a full-depth tap or ring
  assign span_o = (setup_q == '0) ? CNT_W'(DEPTH) : CNT_W'(setup_q);
  assign mode_o = mode_q;

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_q) && $stable(setup_q));
endmodule

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
  import rs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reinit_i,
  input  rs_mode_e         mode_i,
  input  logic [CNT_W-1:0] span_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic             mem_we_o,
  output logic [PTR_W-1:0] mem_waddr_o,
  output logic [PTR_W-1:0] mem_raddr_o,
  output logic             rd_ok_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam logic [PTR_W-1:0] P_ONE = PTR_W'(1);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q, rd_ptr_d, wr_ptr_d, top;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty, full, strict, do_rd, do_wr, pop, push;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == C_FULL);
  assign strict = (mode_i == RS_POPQ) || (mode_i == RS_LIFO);
  assign do_rd  = rd_i & ~reinit_i;
  assign do_wr  = wr_i & ~reinit_i;
  assign pop    = do_rd & ~empty;
  assign push   = do_wr & ~full;
  assign top    = wr_ptr_q - P_ONE;

  assign underflow_o = do_rd & strict & empty;
  assign overflow_o  = do_wr & strict & full;

  always_comb begin
    rd_ptr_d    = rd_ptr_q;
    wr_ptr_d    = wr_ptr_q;
    cnt_d       = cnt_q;
    mem_we_o    = 1'b0;
    mem_waddr_o = wr_ptr_q;
    mem_raddr_o = rd_ptr_q;
    rd_ok_o     = ~empty;
    unique case (mode_i)
      RS_TAPQ: begin
        // span of DEPTH truncates to 0, which selects the oldest slot
        mem_raddr_o = wr_ptr_q - PTR_W'(span_i);
        rd_ok_o     = (cnt_q >= span_i);
        if (do_wr) begin
          mem_we_o = 1'b1;
          wr_ptr_d = wr_ptr_q + P_ONE;
          if (!full) cnt_d = cnt_q + C_ONE;
        end
      end
      RS_POPQ: begin
        if (pop) rd_ptr_d = rd_ptr_q + P_ONE;
        if (push) begin
          mem_we_o = 1'b1;
          wr_ptr_d = wr_ptr_q + P_ONE;
        end
        case ({push, pop})
          2'b10:   cnt_d = cnt_q + C_ONE;
          2'b01:   cnt_d = cnt_q - C_ONE;
          default: cnt_d = cnt_q;
        endcase
      end
      RS_RING: begin
        if (pop) rd_ptr_d = (CNT_W'(rd_ptr_q) + C_ONE == cnt_q) ? '0 : rd_ptr_q + P_ONE;
        if (do_wr && (cnt_q < span_i)) begin
          mem_we_o = 1'b1;
          wr_ptr_d = wr_ptr_q + P_ONE;
          cnt_d    = cnt_q + C_ONE;
        end
      end
      RS_LIFO: begin
        mem_raddr_o = top;
        mem_we_o    = push;
        // simultaneous pop and push replaces the old top
        mem_waddr_o = pop ? top : wr_ptr_q;
        case ({push, pop})
          2'b10: begin
            wr_ptr_d = wr_ptr_q + P_ONE;
            cnt_d    = cnt_q + C_ONE;
          end
          2'b01: begin
            wr_ptr_d = top;
            cnt_d    = cnt_q - C_ONE;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (reinit_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  p_reinit_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (cnt_q == '0) && (rd_ptr_q == '0) && (wr_ptr_q == '0));

  p_tap_read_still_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RS_TAPQ) && rd_i && !wr_i && !reinit_i |=> $stable(cnt_q) && $stable(wr_ptr_q));

  p_underflow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o && !wr_i |=> $stable(cnt_q) && $stable(rd_ptr_q) && $stable(wr_ptr_q));

  p_drop_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !rd_i |=> $stable(cnt_q) && $stable(wr_ptr_q));

  p_cnt_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= C_FULL);

  p_ring_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RS_RING) && !empty |-> CNT_W'(rd_ptr_q) < cnt_q);
endmodule

// File: rtl/rs_array.sv
module rs_array #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  input  logic             rd_ok_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] ent_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign ent_we[g] = we_i && (waddr_i == PTR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) if (ent_we[i]) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = rd_ok_i ? mem_q[raddr_i] : '0;
endmodule

// File: rtl/multimode_regstruct.sv
module multimode_regstruct
  import rs_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_load_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [PTR_W-1:0] cfg_setup_i,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  rs_mode_e         mode;
  logic [CNT_W-1:0] span;
  logic             mem_we, rd_ok;
  logic [PTR_W-1:0] waddr, raddr;

  rs_cfg_reg #(.DEPTH(DEPTH)) u_cfg (
    .clk_i, .rst_ni,
    .load_i(cfg_load_i), .mode_i(cfg_mode_i), .setup_i(cfg_setup_i),
    .mode_o(mode), .span_o(span)
  );

  rs_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .reinit_i(cfg_load_i | clr_i), .mode_i(mode), .span_i(span),
    .rd_i(rd_en_i), .wr_i(wr_en_i),
    .mem_we_o(mem_we), .mem_waddr_o(waddr), .mem_raddr_o(raddr),
    .rd_ok_o(rd_ok), .underflow_o, .overflow_o
  );

  rs_array #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_arr (
    .clk_i, .rst_ni,
    .we_i(mem_we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rd_ok_i(rd_ok), .rdata_o(rd_data_o)
  );

  p_underflow_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> (rd_data_o == '0));

  p_no_dual_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(underflow_o && overflow_o));
endmodule

// File: tb/tb_multimode_regstruct.sv
`timescale 1ns/1ps
module tb_multimode_regstruct;
  localparam int WIDTH = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_load = 1'b0;
  logic [1:0]       cfg_mode = '0;
  logic [2:0]       cfg_setup = '0;
  logic             clr = 1'b0;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic [WIDTH-1:0] rd_data;
  logic             underflow, overflow;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  int               m_mode = 1;
  int               m_setup = 0;
  int               m_idx = 0;
  logic [WIDTH-1:0] mq[$];
  logic [31:0]      lfsr = 32'hACE1_2468;

  always #2 clk = ~clk;

  multimode_regstruct #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_load_i(cfg_load), .cfg_mode_i(cfg_mode), .cfg_setup_i(cfg_setup),
    .clr_i(clr), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .underflow_o(underflow), .overflow_o(overflow)
  );

  function automatic logic [WIDTH-1:0] exp_data();
    int tap;
    if (mq.size() == 0) return '0;
    case (m_mode)
      0: begin
        tap = (m_setup == 0) ? DEPTH : m_setup;
        return (mq.size() >= tap) ? mq[tap-1] : '0;
      end
      1: return mq[0];
      2: return mq[m_idx];
      default: return mq[mq.size()-1];
    endcase
  endfunction

  function automatic bit strict_mode();
    return (m_mode == 1) || (m_mode == 3);
  endfunction

  task automatic check(input string tag);
    bit act;
    logic [WIDTH-1:0] ed;
    logic eu, eo;
    act = !cfg_load && !clr;
    ed = exp_data();
    eu = act && rd_en && strict_mode() && (mq.size() == 0);
    eo = act && wr_en && strict_mode() && (mq.size() == DEPTH);
    vectors++;
    if (rd_data !== ed || underflow !== eu || overflow !== eo) begin
      miscompares++;
      $display("FAIL %s: data=%h uf=%b of=%b expected data=%h uf=%b of=%b",
               tag, rd_data, underflow, overflow, ed, eu, eo);
    end
  endtask

  task automatic model_update();
    int n;
    if (cfg_load) begin
      m_mode = cfg_mode; m_setup = cfg_setup; mq.delete(); m_idx = 0;
    end else if (clr) begin
      mq.delete(); m_idx = 0;
    end else begin
      n = mq.size();
      case (m_mode)
        0: if (wr_en) begin
             mq.push_front(wr_data);
             if (mq.size() > DEPTH) void'(mq.pop_back());
           end
        1: begin
             if (rd_en && n > 0) void'(mq.pop_front());
             if (wr_en && n < DEPTH) mq.push_back(wr_data);
           end
        2: begin
             if (rd_en && n > 0) m_idx = (m_idx + 1 == n) ? 0 : m_idx + 1;
             if (wr_en && n < ((m_setup == 0) ? DEPTH : m_setup)) mq.push_back(wr_data);
           end
        default: begin
             if (rd_en && n > 0) void'(mq.pop_back());
             if (wr_en && n < DEPTH) mq.push_back(wr_data);
           end
      endcase
    end
  endtask

  task automatic step(input logic ld, input logic [1:0] md, input logic [2:0] su,
                      input logic cl, input logic r, input logic w,
                      input logic [WIDTH-1:0] d, input string tag);
    @(negedge clk);
    cfg_load = ld; cfg_mode = md; cfg_setup = su; clr = cl;
    rd_en = r; wr_en = w; wr_data = d;
    #1;
    check(tag);
    @(posedge clk);
    model_update();
  endtask

  task automatic setup_mode(input logic [1:0] md, input logic [2:0] su, input string tag);
    step(1'b1, md, su, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic wr(input logic [WIDTH-1:0] d, input string tag);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, d, tag);
  endtask

  task automatic rd(input string tag);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0, tag);
  endtask

  task automatic rdwr(input logic [WIDTH-1:0] d, input string tag);
    step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1, d, tag);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(4 * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state, idle
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, "R1");
    rd("R1 R5 empty after reset");

    // R2 R3 tapped queue, tap 2; write in config cycle must be ignored (R1)
    step(1'b1, 2'd0, 3'd2, 1'b0, 1'b1, 1'b1, 32'hDEAD_0000, "R1");
    rd("R2");
    wr(32'hA0A0_0001, "R2");
    rd("R2");
    wr(32'hB0B0_0002, "R2");
    rd("R3"); rd("R3"); rd("R3");
    wr(32'hC0C0_0003, "R3");
    rd("R2");
    // tap 0 means DEPTH
    setup_mode(2'd0, 3'd0, "R2");
    for (int i = 0; i < 11; i++) wr(32'h1000 + i, "R2 R3");
    rd("R2"); rd("R3");

    // R4 R10 FIFO with nonzero setup
    setup_mode(2'd1, 3'd5, "R10");
    rd("R5");
    rdwr(32'h5500_0000, "R9");
    for (int i = 0; i < 9; i++) wr(32'h2000 + i, "R4 R6");
    rdwr(32'h2FFF, "R6 R9");
    for (int i = 0; i < 3; i++) begin rd("R4"); wr(32'h2100 + i, "R4"); end
    clr = 1'b0;
    step(1'b0, '0, '0, 1'b1, 1'b1, 1'b1, 32'h9999, "R1");
    rd("R1 R5");

    // R7 ring of length 3
    setup_mode(2'd2, 3'd3, "R7");
    rd("R7");
    for (int i = 0; i < 5; i++) wr(32'h3000 + i, "R7");
    for (int i = 0; i < 7; i++) rd("R7");
    setup_mode(2'd2, 3'd0, "R7");
    wr(32'h3100, "R7");
    rdwr(32'h3101, "R9");
    for (int i = 0; i < 4; i++) rd("R7");

    // R8 stack with setup that must not matter
    setup_mode(2'd3, 3'd6, "R10");
    for (int i = 0; i < 3; i++) wr(32'h4000 + i, "R8");
    rd("R8");
    rdwr(32'h4444, "R9");
    rd("R8"); rd("R8"); rd("R8");
    rd("R5");
    rdwr(32'h4555, "R9");
    for (int i = 0; i < 9; i++) wr(32'h4100 + i, "R6");
    rdwr(32'h4EEE, "R6 R9");
    for (int i = 0; i < 9; i++) rd("R8 R5");

    // mixed traffic across all modes
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (c % 97 == 0)
        step(1'b1, lfsr[1:0], lfsr[4:2], 1'b0, lfsr[5], lfsr[6], lfsr, "R11 mixed");
      else
        step(1'b0, '0, '0, (lfsr[15:10] == 6'd0), lfsr[7] & lfsr[8],
             lfsr[9] | lfsr[16], lfsr, "R11 mixed");
    end

    report();
    $finish;
  end
endmodule